// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Optional Ninth Bit

The block turns a parallel byte into an asynchronous serial frame on one output line. Software writes a byte into a one-entry holding register. When the shifter is idle, the byte moves on into a separate shift register, which serializes it. Because the holding register frees up as soon as that move happens, a second byte can wait in it while the first is still on the line. Two flags report the state of each stage: `buf_empty` for the holding register and `shift_empty` for the shifter. Software polls `buf_empty` before it writes again.

A frame has a low start bit, then the data bits least significant first, then an optional ninth bit, then one high stop bit. The ninth bit and the 8/9-bit choice are both captured with the byte at the moment of the write. Software can use the ninth bit as a parity bit or as an address marker. Bit timing comes from an external baud tick: each bit lasts `TICKS_PER_BIT` ticks, 16 by default, which matches the receiver's oversampling clock.

Clearing the enable stops everything: a frame in flight and a queued byte are both dropped, and the line returns to mark.

The shifter control is a state machine with these states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Line at mark. |
| `ST_START` | Start bit. |
| `ST_DATA` | Data bits. |
| `ST_NINTH` | Ninth bit. |
| `ST_STOP` | Stop bit. |

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→START | Holding register full (a "load"). |
| START→DATA | Bit time done. |
| DATA→DATA | Bit time done, not the last data bit. |
| DATA→NINTH | Last data bit done and 9-bit frame. |
| DATA→STOP | Last data bit done and 8-bit frame. |
| NINTH→STOP | Bit time done. |
| STOP→IDLE | Bit time done. |
| any→IDLE | Enable low (abort). |

Top module: `ser9_tx`

## Requirements
- R1: After reset, `ser_out`=1, `buf_empty`=1 and `shift_empty`=1.
- R2: Whenever `shift_empty` is 1 the line is at mark (`ser_out`=1).
- R3: A frame is a start bit (0), then 8 data bits least significant bit first, then a stop bit (1). Every bit lasts 16 baud ticks (`baud_tick` high at a clock edge).
- R4: If `nine_bit_mode` is 1 at the write, one extra bit is sent between the last data bit and the stop bit. Its value is `ninth_bit` as sampled at the write. If `nine_bit_mode` is 0, no extra bit is sent.
- R5: A write (`wr_stb`=1 at an edge while `tx_en`=1 and `buf_empty`=1) is accepted: `buf_empty` reads 0 after that edge.
- R6: With the shifter idle, a held byte moves into the shifter at the next edge. From that edge on, `buf_empty`=1, `shift_empty`=0 and the start bit is on the line.
- R7: A byte written while a frame is being sent stays held (`buf_empty`=0, `shift_empty`=0). It is sent as the next frame after the current stop bit, with one idle clock in between.
- R8: A write at an edge where `buf_empty`=0 is ignored. The held byte is kept and the new data is never sent.
- R9: A write while `tx_en`=0 is ignored: both flags stay 1 and no frame appears after enabling.
- R10: An edge with `tx_en`=0 aborts any frame and drops any held byte. After it, `ser_out`=1, `buf_empty`=1 and `shift_empty`=1.
- R11: `shift_empty` returns to 1 after the stop bit of the last queued frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and holds idle |
| nine_bit_mode | input | 1 | 1 selects 9-bit frames (captured at write) |
| ninth_bit | input | 1 | Value of the ninth bit (captured at write) |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| baud_tick | input | 1 | One-clock pulse from the external rate generator |
| ser_out | output | 1 | Serial line, mark = 1 |
| buf_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shift register idle |

## Verification
Most faults in the shifter state, the bit counter or the shift register show up on the line within one frame.

- A bit-time counter off by one shifts every later bit. By the ninth or tenth bit the mid-bit sample has drifted into the wrong bit.
- A wrong data shift or a wrong ninth-bit choice corrupts the frame that is decoded.

Faults in the holding register show up differently:

- A lost or duplicated hand-over shows up as a missing frame or an extra frame on the line.
- A flag that is wrong shows one clock after the write edge or the transfer edge.
- An abort that leaves state behind shows as a frame, or a low line, after the enable returns.

// File: rtl/ser9_tx_pkg.sv
package ser9_tx_pkg;

    parameter int unsigned SER9_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_NINTH = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    // Byte plus the frame options captured at the write
    typedef struct packed {
        logic                   nine;
        logic                   ninth;
        logic [SER9_DATA_W-1:0] data;
    } hold_word_t;

endpackage

// File: rtl/ser9_hold_buf.sv
module ser9_hold_buf
    import ser9_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       wr_stb,
    input  hold_word_t wr_word,
    input  logic       take,
    output logic       full,
    output hold_word_t word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (!tx_en) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            word <= wr_word;
        end
    end

endmodule

// File: rtl/ser9_bit_timer.sv
module ser9_bit_timer #(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic baud_tick,
    output logic bit_done
);

    localparam int unsigned CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_done = run && baud_tick && (cnt == LAST_CNT);

endmodule

// File: rtl/ser9_tx_fsm.sv
module ser9_tx_fsm
    import ser9_tx_pkg::*;
#(
    parameter int unsigned DATA_W = SER9_DATA_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       hold_full,
    input  hold_word_t hold_word,
    input  logic       bit_done,
    output logic       load,
    output logic       running,
    output logic       ser_out,
    output logic       shift_empty
);

    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic              nine_q;
    logic              ninth_q;

    assign load = tx_en && (state == ST_IDLE) && hold_full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!tx_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (hold_full) state_nx = ST_START;
                ST_START: if (bit_done)  state_nx = ST_DATA;
                ST_DATA:  if (bit_done && bit_idx == LAST_IDX)
                              state_nx = nine_q ? ST_NINTH : ST_STOP;
                ST_NINTH: if (bit_done)  state_nx = ST_STOP;
                ST_STOP:  if (bit_done)  state_nx = ST_IDLE;
                default:                 state_nx = ST_IDLE;
            endcase
        end
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            nine_q  <= 1'b0;
            ninth_q <= 1'b0;
        end else if (load) begin
            shreg   <= hold_word.data;
            bit_idx <= '0;
            nine_q  <= hold_word.nine;
            ninth_q <= hold_word.ninth;
        end else if (tx_en && state == ST_DATA && bit_done) begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ser_out = 1'b1;
        unique case (state)
            ST_IDLE:  ser_out = 1'b1;
            ST_START: ser_out = 1'b0;
            ST_DATA:  ser_out = shreg[0];
            ST_NINTH: ser_out = ninth_q;
            ST_STOP:  ser_out = 1'b1;
            default:  ser_out = 1'b1;
        endcase
        shift_empty = (state == ST_IDLE);
        running     = (state != ST_IDLE);
    end

endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
    import ser9_tx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_en,
    input  logic                   nine_bit_mode,
    input  logic                   ninth_bit,
    input  logic                   wr_stb,
    input  logic [SER9_DATA_W-1:0] wr_data,
    input  logic                   baud_tick,
    output logic                   ser_out,
    output logic                   buf_empty,
    output logic                   shift_empty
);

    hold_word_t wr_word, hold_word;
    logic       hold_full, load, running, bit_done;

    assign wr_word = '{nine: nine_bit_mode, ninth: ninth_bit, data: wr_data};

    ser9_hold_buf u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .wr_stb  (wr_stb),
        .wr_word (wr_word),
        .take    (load),
        .full    (hold_full),
        .word    (hold_word)
    );

    ser9_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load || !tx_en),
        .run       (running),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    ser9_tx_fsm #(.DATA_W(SER9_DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .hold_full   (hold_full),
        .hold_word   (hold_word),
        .bit_done    (bit_done),
        .load        (load),
        .running     (running),
        .ser_out     (ser_out),
        .shift_empty (shift_empty)
    );

    assign buf_empty = !hold_full;

endmodule

// File: rtl/ser9_tx_chk.sv
module ser9_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_stb,
    input logic ser_out,
    input logic buf_empty,
    input logic shift_empty
);

    p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> ser_out);

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !ser_out);

    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_stb && buf_empty) |=> !buf_empty);

    p_transfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !buf_empty && shift_empty) |=> (buf_empty && !shift_empty));

    p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !buf_empty && !shift_empty) |=> !buf_empty);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (ser_out && buf_empty && shift_empty));

endmodule

bind ser9_tx ser9_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .wr_stb      (wr_stb),
    .ser_out     (ser_out),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty)
);

// File: tb/tb_ser9_tx.sv
module tb_ser9_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       ninth_bit = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic       ser_out, buf_empty, shift_empty;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ser9_tx dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_bit_mode(nine_bit_mode),
        .ninth_bit(ninth_bit), .wr_stb(wr_stb), .wr_data(wr_data),
        .baud_tick(baud_tick), .ser_out(ser_out), .buf_empty(buf_empty),
        .shift_empty(shift_empty)
    );

    // Baud tick every second clock, driven after the edge
    logic [1:0] tdiv = 2'd0;
    always @(posedge clk) begin
        #2;
        tdiv = tdiv + 2'd1;
        baud_tick = tdiv[0];
    end

    int tick_total = 0;
    always @(posedge clk) if (baud_tick) tick_total++;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected entry: {nine, ninth, data}
    logic [9:0] expq[$];

    function automatic logic exp_bit(input logic [9:0] e, input int i);
        if (i == 0)      return 1'b0;
        else if (i <= 8) return e[i-1];
        else if (i == 9) return e[9] ? e[8] : 1'b1;
        else             return 1'b1;
    endfunction

    function automatic int exp_len(input logic [9:0] e);
        return e[9] ? 11 : 10;
    endfunction

    // Line monitor: samples every bit in its middle, counted in baud ticks
    logic        mbusy = 1'b0;
    logic        mvalid = 1'b0;
    int          t0 = 0;
    int          midx = 0;
    logic [9:0]  mcur = '0;
    logic [10:0] mgot = '0;
    logic [10:0] mexp = '0;

    always @(negedge clk) begin
        if (!rst_n || !tx_en) begin
            mbusy = 1'b0;
            if (!tx_en) expq.delete();
        end else if (!mbusy) begin
            if (!ser_out) begin
                mbusy = 1'b1;
                t0 = tick_total;
                midx = 0;
                mgot = '0;
                if (expq.size() == 0) begin
                    mvalid = 1'b0;
                    check(1'b0, "R8/R9 unexpected frame", 1, 0);
                end else begin
                    mvalid = 1'b1;
                    mcur = expq[0];
                end
            end
        end else if (tick_total >= t0 + 8 + 16*midx) begin
            mgot[midx] = ser_out;
            midx++;
            if (midx == (mvalid ? exp_len(mcur) : 10)) begin
                mbusy = 1'b0;
                if (mvalid) begin
                    mexp = '0;
                    for (int i = 0; i < exp_len(mcur); i++) mexp[i] = exp_bit(mcur, i);
                    check(mgot == mexp, mcur[9] ? "R3/R4 9-bit frame" : "R3/R4 8-bit frame",
                          int'(mgot), int'(mexp));
                    void'(expq.pop_front());
                end
            end
        end
    end

    task automatic drive_write(input logic [7:0] d, input logic nine, input logic n9,
                               input logic accept);
        @(posedge clk); #2;
        wr_stb = 1'b1; wr_data = d; nine_bit_mode = nine; ninth_bit = n9;
        @(posedge clk); #2;
        wr_stb = 1'b0;
        if (accept) expq.push_back({nine, n9, d});
    endtask

    task automatic drain();
        @(negedge clk);
        while (!(shift_empty && buf_empty && expq.size() == 0 && !mbusy)) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            summary();
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ser_out == 1'b1, "R1 ser_out", ser_out, 1);
        check(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        check(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);

        // R9: write while disabled is ignored
        drive_write(8'hA5, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(buf_empty == 1'b1, "R9 buf_empty stays", buf_empty, 1);
        @(posedge clk); #2 tx_en = 1'b1;
        repeat (60) @(negedge clk);
        check(shift_empty == 1'b1 && ser_out == 1'b1, "R9 no frame", {shift_empty, ser_out}, 3);

        // R5/R6: accept, then transfer one clock later
        drive_write(8'h3C, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check(buf_empty == 1'b0, "R5 buf_empty after write", buf_empty, 0);
        check(shift_empty == 1'b1, "R5 shifter still idle", shift_empty, 1);
        @(negedge clk);
        check(buf_empty == 1'b1 && shift_empty == 1'b0, "R6 transfer flags",
              {buf_empty, shift_empty}, 2);
        check(ser_out == 1'b0, "R6 start bit", ser_out, 0);
        // R7: queue during transmission, 9-bit with ninth = 1
        drive_write(8'hC3, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check(buf_empty == 1'b0 && shift_empty == 1'b0, "R7 queued while shifting",
              {buf_empty, shift_empty}, 0);
        drain();
        check(shift_empty == 1'b1 && ser_out == 1'b1, "R11 idle after frames",
              {shift_empty, ser_out}, 3);

        // R8: write on the transfer edge is ignored
        @(posedge clk); #2;
        wr_stb = 1'b1; wr_data = 8'h81; nine_bit_mode = 1'b1; ninth_bit = 1'b0;
        expq.push_back({1'b1, 1'b0, 8'h81});
        @(posedge clk); #2;
        wr_data = 8'hFF; nine_bit_mode = 1'b0;
        @(posedge clk); #2;
        wr_stb = 1'b0;
        @(negedge clk);
        check(buf_empty == 1'b1, "R8 second write dropped", buf_empty, 1);
        drain();
        check(shift_empty == 1'b1, "R11 idle after R8 case", shift_empty, 1);

        // R10: abort mid-frame with a byte queued
        drive_write(8'h55, 1'b1, 1'b0, 1'b1);
        repeat (90) @(negedge clk);
        drive_write(8'h66, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #2 tx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(ser_out == 1'b1 && buf_empty == 1'b1 && shift_empty == 1'b1, "R10 abort",
              {ser_out, buf_empty, shift_empty}, 7);
        repeat (5) @(posedge clk);
        #2 tx_en = 1'b1;
        repeat (80) @(negedge clk);
        check(ser_out == 1'b1 && shift_empty == 1'b1, "R10 nothing after re-enable",
              {ser_out, shift_empty}, 3);
        drive_write(8'h0F, 1'b0, 1'b0, 1'b1);
        drain();

        // Random traffic: R3, R4, R7
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d;
            logic       nm, nb;
            d  = 8'($urandom);
            nm = 1'($urandom);
            nb = 1'($urandom);
            @(negedge clk);
            while (!buf_empty) @(negedge clk);
            drive_write(d, nm, nb, 1'b1);
            repeat ($urandom % 40) @(posedge clk);
        end
        drain();
        check(expq.size() == 0 && shift_empty == 1'b1, "R11 all frames sent",
              expq.size(), 0);
        summary();
    end

endmodule